// File: doc/BRIEF.md
# Duty-Limited Boost Gate Controller

This block drives the switch gate of a boost converter from a main switching-clock enable pulse. It groups main-clock periods into frames of three. In the last period of each frame, a ramp counter clocked by the fast system clock climbs from zero. When the ramp passes a digital error code, a set/reset latch drives the gate high. The divided-clock edge that ends the frame drops the gate again. The turn-on edge moves with the error code, while the turn-off edge is fixed, so the modulation is front-edge. The gate can only be high inside one period of every three, which hard-limits the duty to one third.

The error code comes from an external error amplifier and converter. It is a plain parallel word, sampled on every clock, with no handshake. The block has no data stream, so all pins are plain control signals: there is no valid/ready and no back-pressure. The enable input is tied to the enable of the main 5 V converter, so the boost starts together with that rail. A separate disable input holds the gate low for good on boards that have no boost stage fitted.

The main tick is a one-cycle pulse, one every `STEPS` fast clocks. The ramp therefore has `STEPS` steps per main period.

Top module: `boost_gate_ctrl`

## Requirements
- R1: After reset, and whenever the block is not running, `gate` is 0.
- R2: While running, the ticks are grouped into frames of three. The first tick after the block starts running begins frame position 0. The ramp window is the main period that starts with the second tick after a frame start. The frame ends at the third tick.
- R3: In the ramp window, with error code E and `STEPS` fast cycles per period, `gate` is high for exactly max(0, STEPS-2-E) fast cycles, counted as values seen after clock edges. It rises E+2 clock edges after the tick that opens the window.
- R4: The tick that closes the ramp window (the divided-clock edge) forces `gate` to 0 at that clock edge.
- R5: In the two main periods of each frame outside the ramp window, `gate` stays 0.
- R6: Dropping `enable` forces `gate` to 0 at the next edge. It also clears the frame position, the ramp and the latch, so a later start is aligned to the first tick after `enable` rises again.
- R7: While `no_boost` is 1, `gate` stays 0 regardless of ticks and error code.
- R8: An error code of STEPS-2 or more never turns the gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the ramp and the logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One-cycle pulse at the start of each main switching period |
| enable | input | 1 | Run request, tied to the 5 V main converter enable |
| no_boost | input | 1 | Held 1 when no boost stage is fitted |
| err_code | input | CNT_W | Error amplifier value, compared with the ramp |
| gate | output | 1 | Boost switch gate drive |

## Verification
On every cycle, the assertions check the following:
- the gate is high only inside the ramp window;
- the closing tick and a stopped block both pull the gate low;
- the frame position never leaves its three legal values;
- the latch sets once the ramp has passed the error code.

Only the bench scenarios can show the full frame picture. They measure the exact number of high cycles against several error codes, check the alignment after a restart, and confirm that large codes and the disable input keep the gate quiet over whole frames.

// File: rtl/boost_pkg.sv
package boost_pkg;
  typedef enum logic [1:0] {
    POS_REST = 2'd0,
    POS_WAIT = 2'd1,
    POS_RAMP = 2'd2
  } frame_pos_e;
endpackage

// File: rtl/frame_divider.sv
module frame_divider
  import boost_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  output frame_pos_e pos,
  output logic       win_o,
  output logic       close_o
);
  frame_pos_e pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= POS_REST;
    end else if (!run) begin
      pos_q <= POS_REST;
    end else if (tick) begin
      unique case (pos_q)
        POS_REST: pos_q <= POS_WAIT;
        POS_WAIT: pos_q <= POS_RAMP;
        default:  pos_q <= POS_REST;
      endcase
    end
  end

  assign pos     = pos_q;
  assign win_o   = (pos_q == POS_RAMP);
  assign close_o = run && tick && (pos_q == POS_RAMP);
endmodule

// File: rtl/ramp_counter.sv
module ramp_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             win,
  output logic [CNT_W-1:0] ramp
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  logic [CNT_W-1:0] ramp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp_q <= '0;
    end else if (!run || tick) begin
      ramp_q <= '0;
    end else if (win && ramp_q != TOP) begin
      ramp_q <= ramp_q + 1'b1;
    end
  end

  assign ramp = ramp_q;
endmodule

// File: rtl/gate_latch.sv
module gate_latch #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             win,
  input  logic             close,
  input  logic [CNT_W-1:0] ramp,
  input  logic [CNT_W-1:0] err,
  output logic             q
);
  logic q_r;
  logic set_w;

  assign set_w = win && !tick && (ramp > err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (!run || close) begin
      q_r <= 1'b0;
    end else if (set_w) begin
      q_r <= 1'b1;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/boost_gate_ctrl.sv
module boost_gate_ctrl #(
  parameter int STEPS = 16,
  localparam int CNT_W = $clog2(STEPS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             main_tick,
  input  logic             enable,
  input  logic             no_boost,
  input  logic [CNT_W-1:0] err_code,
  output logic             gate
);
  import boost_pkg::*;

  logic             run;
  frame_pos_e       pos;
  logic             win;
  logic             close;
  logic [CNT_W-1:0] ramp;

  assign run = enable && !no_boost;

  frame_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (main_tick),
    .pos     (pos),
    .win_o   (win),
    .close_o (close)
  );

  ramp_counter #(.CNT_W(CNT_W)) u_ramp (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (main_tick),
    .win   (win),
    .ramp  (ramp)
  );

  gate_latch #(.CNT_W(CNT_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .tick  (main_tick),
    .win   (win),
    .close (close),
    .ramp  (ramp),
    .err   (err_code),
    .q     (gate)
  );
endmodule

// File: rtl/boost_gate_chk.sv
module boost_gate_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             main_tick,
  input logic             enable,
  input logic             no_boost,
  input logic [CNT_W-1:0] err_code,
  input logic [1:0]       pos,
  input logic [CNT_W-1:0] ramp,
  input logic             gate
);
  AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable || no_boost) |=> !gate); // R6
  AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    no_boost |=> !gate); // R7
  AST_CLOSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (main_tick && pos == 2'd2) |=> !gate); // R4
  AST_GATE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (pos == 2'd2)); // R5
  AST_POS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pos != 2'd3); // R2
  AST_SET_ON_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !no_boost && !main_tick && pos == 2'd2 && ramp > err_code)
      |=> gate); // R3
  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> !gate); // R1
endmodule

bind boost_gate_ctrl boost_gate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .main_tick (main_tick),
  .enable    (enable),
  .no_boost  (no_boost),
  .err_code  (err_code),
  .pos       (pos),
  .ramp      (ramp),
  .gate      (gate)
);

// File: tb/boost_gate_ctrl_bench.sv
module boost_gate_ctrl_bench;
  localparam int S = 16;
  localparam int W = $clog2(S + 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         main_tick = 1'b0;
  logic         enable = 1'b0;
  logic         no_boost = 1'b0;
  logic [W-1:0] err_code = '0;
  logic         gate;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;

  boost_gate_ctrl #(.STEPS(S)) u_boost_gate_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_tick (main_tick),
    .enable    (enable),
    .no_boost  (no_boost),
    .err_code  (err_code),
    .gate      (gate)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // driver: pushes expected high count; per-cycle monitor inline, count popped at end
  task automatic run_frame(input int err);
    int cnt = 0;
    int e;
    int ex;
    exp_q.push_back((S - 2 - err) > 0 ? (S - 2 - err) : 0);
    err_code = W'(err);
    for (int off = 0; off < 3 * S; off++) begin
      @(negedge clk);
      e  = (off == 0) ? 3 * S - 1 : off - 1;
      ex = (e >= S + err + 2 && e <= 2 * S - 1) ? 1 : 0;
      if (off > 0) cnt += int'(gate);
      if (e < S || e >= 2 * S) check("R5 idle periods low", int'(gate), 0);
      else if (err >= S - 2) check("R8 large code never sets", int'(gate), 0);
      else check("R3 gate edge timing", int'(gate), ex);
      main_tick = (off % S == 0);
    end
    @(negedge clk);
    check("R4 close edge drops gate", int'(gate), 0);
    main_tick = 1'b0;
    check("R3 high count per frame", cnt, exp_q.pop_front());
  endtask

  task automatic quiet_frames(input string req, input int nfr);
    int hi = 0;
    for (int off = 0; off < 3 * S * nfr; off++) begin
      @(negedge clk);
      hi += int'(gate);
      main_tick = (off % S == 0);
    end
    @(negedge clk);
    main_tick = 1'b0;
    check(req, hi, 0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset gate", int'(gate), 0);
    rst_n = 1'b1;
    err_code = '0;
    quiet_frames("R1 not running stays low", 1);

    enable = 1'b1;
    run_frame(5);
    run_frame(0);
    run_frame(13);
    run_frame(3);
    run_frame(S - 2);
    run_frame(31);
    run_frame(9);

    // R6: drop enable mid window while gate high
    err_code = '0;
    for (int off = 0; off < S + 8; off++) begin
      @(negedge clk);
      main_tick = (off % S == 0);
    end
    main_tick = 1'b0;
    @(negedge clk);
    check("R6 gate high before drop", int'(gate), 1);
    enable = 1'b0;
    @(negedge clk);
    check("R6 drop forces low", int'(gate), 0);
    quiet_frames("R6 stopped stays low", 1);
    enable = 1'b1;
    run_frame(2);
    run_frame(7);

    // R7: no boost fitted
    no_boost = 1'b1;
    err_code = '0;
    quiet_frames("R7 no_boost holds low", 2);
    no_boost = 1'b0;
    run_frame(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule